// File: doc/BRIEF.md
# PCI-to-DMA Window Address Translator

This block turns an address seen on a PCI bus into a system DMA address. Four programmable windows are compared against each incoming address. Each window has a base word, a mask word and a translated base. The lowest-numbered window that matches and is enabled decides the translation. A window either maps the address directly onto its translated base, or it looks the page up in a scatter-gather table held in system memory. If no enabled window matches, the address is returned unchanged.

A requester hands in one address with a valid/ready handshake and gets the result back on a one-cycle valid strobe. For a scatter-gather window the block issues a single 64-bit read request for the page-table entry. It waits for the memory's response strobe, then builds the final address from the returned entry. The block handles one address at a time. The window words are driven as flat vectors and must stay stable while an address is being accepted.

Top module: `pci_dma_xlate`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `in_ready` is 1, and `out_valid` and `rd_req` are 0.
- R2: Window i matches when the bus address and bit-slice i of `win_base` agree on every bit in 31:20 where bit-slice i of `win_mask` is 0. Mask and address bits 19:0 take no part in the compare.
- R3: Bit 0 of a window's base word is its enable. A disabled window is never used, even when it matches.
- R4: Among windows that both match and are enabled, the lowest index is used.
- R5: For a direct window (base bit 1 is 0), let K be mask bits 31:20 ORed with 0x000FFFFF. The result is (translated base AND NOT K) OR (bus address AND K).
- R6: For a window with base bit 1 set (scatter-gather), `rd_req` pulses for exactly one cycle. `rd_addr` then equals (translated base AND NOT(((mask AND 0xFFF00000) >> 10) OR 0x3FF)) OR ((bus address AND ((mask AND 0xFFF00000) OR 0x000FE000)) >> 10).
- R7: The scatter-gather result equals the response word with bit 0 cleared, shifted left by 12, ORed with bus address bits 12:0.
- R8: Every result is 34 bits wide. Response bits 63:22 have no effect on the scatter-gather result.
- R9: When no window both matches and is enabled, `out_addr` equals the bus address, zero-extended.
- R10: `in_ready` is 0 from the cycle after acceptance through the result strobe cycle, and it is 1 again on the following cycle.
- R11: A direct or pass-through result is strobed one cycle after acceptance. `rd_req` comes one cycle after acceptance. A scatter-gather result is strobed one cycle after `rd_valid` is seen.
- R12: `out_valid` is a single-cycle pulse, given once per accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bus address offered |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 32 | PCI bus address |
| win_base | input | 4*32 | Window base words; bit 0 enable, bit 1 scatter-gather |
| win_mask | input | 4*32 | Window mask words; bits 31:20 used |
| win_tbase | input | 4*34 | Window translated bases |
| rd_req | output | 1 | Page-table entry read request pulse |
| rd_addr | output | 34 | Page-table entry address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 64 | Read response word |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 34 | Translated DMA address |

## Verification
Direct and pass-through results are due on the first cycle after the accepting edge. The bench reads `out_addr` at the falling edge that follows that edge. A scatter-gather request is read at the same point. The memory model then waits zero to three cycles before it returns the entry, and the result is read one falling edge after the response strobe. At each of these points the bench also checks that `in_ready` is low, and one cycle later it checks that `in_ready` is high again and the strobe has dropped. Two window configurations are swept over a spread of addresses and a set of directed addresses, with each result computed arithmetically from the window words.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } pdt_state_e;

  // log2 of the table entry size in bytes
  localparam int ENTRY_BYTES_LOG2 = 3;
endpackage

// File: rtl/pdt_window_hit.sv
module pdt_window_hit #(
  parameter int NWIN   = 4,
  parameter int BUS_W  = 32,
  parameter int CMP_LO = 20
) (
  input  logic [BUS_W-1:0]      bus_addr,
  input  logic [NWIN*BUS_W-1:0] base_vec,
  input  logic [NWIN*BUS_W-1:0] mask_vec,
  output logic [NWIN-1:0]       hit
);
  localparam logic [BUS_W-1:0] LOW_ONES  = {{(BUS_W-CMP_LO){1'b0}}, {CMP_LO{1'b1}}};
  localparam logic [BUS_W-1:0] CMP_FIELD = ~LOW_ONES;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [BUS_W-1:0] base_w;
    logic [BUS_W-1:0] cmp_w;
    assign base_w = base_vec[i*BUS_W +: BUS_W];
    assign cmp_w  = ~mask_vec[i*BUS_W +: BUS_W] & CMP_FIELD;
    assign hit[i] = base_w[0] && (((bus_addr ^ base_w) & cmp_w) == '0);
  end
endmodule

// File: rtl/pdt_first_pick.sv
module pdt_first_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/pdt_addr_calc.sv
module pdt_addr_calc import pdt_pkg::*; #(
  parameter int BUS_W     = 32,
  parameter int DMA_W     = 34,
  parameter int PTE_W     = 64,
  parameter int CMP_LO    = 20,
  parameter int PAGE_BITS = 13
) (
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] mask,
  input  logic [DMA_W-1:0] tbase,
  input  logic [BUS_W-1:0] held_addr,
  input  logic [PTE_W-1:0] entry,
  output logic [DMA_W-1:0] direct_addr,
  output logic [DMA_W-1:0] entry_addr,
  output logic [DMA_W-1:0] sg_addr
);
  localparam int W0        = (PTE_W > DMA_W) ? PTE_W : DMA_W;
  localparam int W         = (W0 > BUS_W) ? W0 : BUS_W;
  localparam int IDX_SHIFT = PAGE_BITS - ENTRY_BYTES_LOG2;

  localparam logic [W-1:0] LOW_ONES   = W'({CMP_LO{1'b1}});
  localparam logic [W-1:0] FIELD      = W'({(BUS_W-CMP_LO){1'b1}}) << CMP_LO;
  localparam logic [W-1:0] IDX_ONES   = W'({IDX_SHIFT{1'b1}});
  localparam logic [W-1:0] SG_FIELD   = W'({(CMP_LO-PAGE_BITS){1'b1}}) << PAGE_BITS;
  localparam logic [W-1:0] PAGE_ONES  = W'({PAGE_BITS{1'b1}});
  localparam logic [W-1:0] VALID_BIT  = W'(1);

  logic [W-1:0] bus_w, held_w, tb_w, mfield, keep_bus, tb_keep, sg_bus;

  assign bus_w    = W'(bus_addr);
  assign held_w   = W'(held_addr);
  assign tb_w     = W'(tbase);
  assign mfield   = W'(mask) & FIELD;
  assign keep_bus = mfield | LOW_ONES;
  assign tb_keep  = ~((mfield >> IDX_SHIFT) | IDX_ONES);
  assign sg_bus   = mfield | SG_FIELD;

  assign direct_addr = DMA_W'((tb_w & ~keep_bus) | (bus_w & keep_bus));
  assign entry_addr  = DMA_W'((tb_w & tb_keep) | ((bus_w & sg_bus) >> IDX_SHIFT));
  assign sg_addr     = DMA_W'(((W'(entry) & ~VALID_BIT) << (PAGE_BITS - 1)) | (held_w & PAGE_ONES));
endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate import pdt_pkg::*; #(
  parameter int NWIN      = 4,
  parameter int BUS_W     = 32,
  parameter int DMA_W     = 34,
  parameter int PTE_W     = 64,
  parameter int CMP_LO    = 20,
  parameter int PAGE_BITS = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BUS_W-1:0]      in_addr,
  input  logic [NWIN*BUS_W-1:0] win_base,
  input  logic [NWIN*BUS_W-1:0] win_mask,
  input  logic [NWIN*DMA_W-1:0] win_tbase,
  output logic                  rd_req,
  output logic [DMA_W-1:0]      rd_addr,
  input  logic                  rd_valid,
  input  logic [PTE_W-1:0]      rd_data,
  output logic                  out_valid,
  output logic [DMA_W-1:0]      out_addr
);
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  pdt_state_e       state;
  logic [BUS_W-1:0] held_addr;
  logic [NWIN-1:0]  hit;
  logic             any_hit;
  logic [IDX_W-1:0] sel;
  logic             sel_sg;
  logic [BUS_W-1:0] sel_mask;
  logic [DMA_W-1:0] sel_tbase;
  logic [DMA_W-1:0] direct_addr, entry_addr, sg_addr;

  pdt_window_hit #(.NWIN(NWIN), .BUS_W(BUS_W), .CMP_LO(CMP_LO)) u_hit (
    .bus_addr (in_addr),
    .base_vec (win_base),
    .mask_vec (win_mask),
    .hit      (hit)
  );

  pdt_first_pick #(.N(NWIN), .IDX_W(IDX_W)) u_pick (
    .req (hit),
    .any (any_hit),
    .idx (sel)
  );

  assign sel_sg    = win_base[32'(sel) * BUS_W + 1];
  assign sel_mask  = win_mask[32'(sel) * BUS_W +: BUS_W];
  assign sel_tbase = win_tbase[32'(sel) * DMA_W +: DMA_W];

  pdt_addr_calc #(
    .BUS_W(BUS_W), .DMA_W(DMA_W), .PTE_W(PTE_W),
    .CMP_LO(CMP_LO), .PAGE_BITS(PAGE_BITS)
  ) u_calc (
    .bus_addr    (in_addr),
    .mask        (sel_mask),
    .tbase       (sel_tbase),
    .held_addr   (held_addr),
    .entry       (rd_data),
    .direct_addr (direct_addr),
    .entry_addr  (entry_addr),
    .sg_addr     (sg_addr)
  );

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held_addr <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      rd_req    <= 1'b0;
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            held_addr <= in_addr;
            if (any_hit && sel_sg) begin
              rd_req  <= 1'b1;
              rd_addr <= entry_addr;
              state   <= ST_WAIT;
            end else begin
              out_valid <= 1'b1;
              out_addr  <= any_hit ? direct_addr : DMA_W'(in_addr);
              state     <= ST_DONE;
            end
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            out_valid <= 1'b1;
            out_addr  <= sg_addr;
            state     <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int DMA_W     = 34,
  parameter int PTE_W     = 64,
  parameter int PAGE_BITS = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [PTE_W-1:0] rd_data,
  input logic             out_valid,
  input logic [DMA_W-1:0] out_addr
);
  logic pend;
  logic pend_now;

  assign pend_now = pend || rd_req;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= pend_now && !rd_valid;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid && !rd_req));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_strobe_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_req_follows_accept_R11: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> $past(in_valid && in_ready));

  assert_entry_result_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_now && rd_valid) |=>
      (out_valid && (out_addr[DMA_W-1:PAGE_BITS] == $past(rd_data[DMA_W-PAGE_BITS:1]))));
endmodule

bind pci_dma_xlate pdt_checker #(.DMA_W(DMA_W), .PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .out_valid (out_valid),
  .out_addr  (out_addr)
);

// File: tb/pci_dma_xlate_test.sv
`timescale 1ns/1ps
module pci_dma_xlate_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_addr = '0;
  logic [127:0] win_base = '0;
  logic [127:0] win_mask = '0;
  logic [135:0] win_tbase = '0;
  logic         rd_req;
  logic [33:0]  rd_addr;
  logic         rd_valid = 1'b0;
  logic [63:0]  rd_data = '0;
  logic         out_valid;
  logic [33:0]  out_addr;

  int checks = 0;
  int failures = 0;
  int ntrans = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_dma_xlate uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .win_base(win_base), .win_mask(win_mask), .win_tbase(win_tbase),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] m, input logic [33:0] t);
    win_base[i*32 +: 32]  = b;
    win_mask[i*32 +: 32]  = m;
    win_tbase[i*34 +: 34] = t;
  endtask

  function automatic logic [63:0] mem_word(input logic [33:0] a);
    return {~a[31:0], a[31:0] ^ 32'h0015_5AA1};
  endfunction

  // kind: 0 pass-through, 1 direct, 2 scatter-gather (v = entry address)
  function automatic void model(input logic [31:0] a, output int kind, output logic [33:0] v);
    kind = 0;
    v = {2'b00, a};
    for (int i = 0; i < 4; i++) begin
      logic [31:0] b, m, mf;
      logic [33:0] t, k, tk;
      b = win_base[i*32 +: 32];
      m = win_mask[i*32 +: 32];
      t = win_tbase[i*34 +: 34];
      mf = m & 32'hFFF0_0000;
      if (kind == 0 && b[0] && (((a ^ b) & ~m & 32'hFFF0_0000) == 32'h0)) begin
        if (b[1]) begin
          kind = 2;
          tk = ~{2'b00, (mf >> 10) | 32'h0000_03FF};
          v = (t & tk) | {2'b00, (a & (mf | 32'h000F_E000)) >> 10};
        end else begin
          kind = 1;
          k = {2'b00, mf | 32'h000F_FFFF};
          v = (t & ~k) | ({2'b00, a} & k);
        end
      end
    end
  endfunction

  task automatic run_one(input logic [31:0] a, input string tag);
    int kind;
    logic [33:0] v;
    logic [63:0] w;
    logic [33:0] e;
    int d;
    model(a, kind, v);
    d = ntrans % 4;
    ntrans++;
    @(negedge clk);
    chk(in_ready == 1'b1, {tag, " R10 ready before offer"}, 64'(in_ready), 64'd1);
    in_valid = 1'b1;
    in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, {tag, " R10 busy"}, 64'(in_ready), 64'd0);
    if (kind == 2) begin
      chk(rd_req == 1'b1, {tag, " R11 request timing"}, 64'(rd_req), 64'd1);
      chk(rd_addr == v, {tag, " R6 entry address"}, 64'(rd_addr), 64'(v));
      chk(out_valid == 1'b0, {tag, " R11 no early strobe"}, 64'(out_valid), 64'd0);
      for (int j = 0; j < d; j++) begin
        @(negedge clk);
        chk(rd_req == 1'b0, {tag, " R6 single request"}, 64'(rd_req), 64'd0);
        chk(out_valid == 1'b0 && in_ready == 1'b0, {tag, " R10 waiting"},
            64'({out_valid, in_ready}), 64'd0);
      end
      w = mem_word(v);
      rd_valid = 1'b1;
      rd_data = w;
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data = '0;
      e = {w[21:1], a[12:0]};
      chk(out_valid == 1'b1, {tag, " R11 entry result timing"}, 64'(out_valid), 64'd1);
      chk(out_addr == e, {tag, " R7/R8 entry result"}, 64'(out_addr), 64'(e));
      chk(in_ready == 1'b0, {tag, " R10 busy at strobe"}, 64'(in_ready), 64'd0);
    end else begin
      chk(out_valid == 1'b1, {tag, " R11 result timing"}, 64'(out_valid), 64'd1);
      chk(out_addr == v, {tag, (kind == 1) ? " R2/R5 direct result" : " R9 pass-through"},
          64'(out_addr), 64'(v));
    end
    @(negedge clk);
    chk(out_valid == 1'b0, {tag, " R12 strobe pulse"}, 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, {tag, " R10 ready again"}, 64'(in_ready), 64'd1);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 48; i++) begin
      run_one(32'(i) * 32'h3A5C_1F17 + 32'h0000_1234, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && rd_req == 1'b0, "R1 in reset",
        64'({in_ready, out_valid, rd_req}), 64'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && rd_req == 1'b0, "R1 after reset",
        64'({in_ready, out_valid, rd_req}), 64'b100);

    // configuration A
    set_win(0, 32'h4000_0001, 32'h0FF0_0000, 34'h2_A000_0000);
    set_win(1, 32'h8000_0003, 32'h0070_0000, 34'h1_2345_6000);
    set_win(2, 32'hC000_0000, 32'h0000_0000, 34'h0_5000_0000);
    set_win(3, 32'h4010_0001, 32'h0000_0000, 34'h3_FFF0_0000);
    run_one(32'h4123_4567, "R5 direct A");
    @(negedge clk);
    chk(out_addr == 34'h2_A123_4567, "R5 direct hand value", 64'(out_addr), 64'h2_A123_4567);
    run_one(32'h4010_0ABC, "R4 priority low window");
    run_one(32'h8012_3FFF, "R6 entry fetch");
    run_one(32'h80FF_FFFF, "R2 mask don't-care bits");
    run_one(32'hC000_0010, "R3 disabled window");
    run_one(32'h0000_0042, "R9 no window");
    sweep("sweep A");

    // configuration B
    set_win(0, 32'h4000_0000, 32'h0FF0_0000, 34'h2_A000_0000);
    set_win(1, 32'h8000_0001, 32'h0FF0_0000, 34'h0_0000_0000);
    set_win(2, 32'hC000_0003, 32'h00F0_0000, 34'h0_8000_0000);
    run_one(32'h4010_0ABC, "R3/R4 lower window disabled");
    run_one(32'h4123_4567, "R3 disabled pass");
    run_one(32'hC0A5_5555, "R8 entry fetch B");
    sweep("sweep B");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule